// File: doc/BRIEF.md
# Periodic Countdown Timer with Word-Addressed Registers

This block is a 32-bit timer that counts down by one on every clock while it runs. Software reaches it through a simple bus that carries one full word per access. It has four registers. Software writes a period, which also loads the live counter at once. It starts and halts the counter with two command bits in the control word. It can read the live count at any moment through a read-only window.

When the counter runs out, a timeout flag is raised. In one-shot operation the counter then rests at zero and stops. In continuous operation it reloads from the period and keeps running. A level interrupt follows the timeout flag, gated by an enable bit. Writing any value to the status word clears the flag.

Top module: `cntdn_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and `irq` is low.
- R2: A write to the period word (byte offset 0x8) stores the value and loads it into the live counter at the same clock edge. The count is visible in the snapshot word (byte offset 0xC) from the next cycle on.
- R3: Writing the control word (offset 0x4) with bit 2 set and bit 3 clear starts the counter if the live count is nonzero. While running, status bit 1 reads 1 and the count falls by exactly one per clock.
- R4: A control write with bit 3 set stops the counter at that edge, even when bit 2 is also set.
- R5: If the counter is started with N, the timeout flag (status bit 0) is set at the N-th running edge, when the count leaves 1. In one-shot operation (control bit 1 clear) the counter is then left at zero and stopped.
- R6: With control bit 1 set, an expiry reloads the counter from the period word and counting goes on without a gap.
- R7: A write of any value to the status word (offset 0x0) clears the timeout flag and leaves the running bit alone. An expiry at the same edge wins and keeps the flag set.
- R8: `irq` is high exactly when the timeout flag and control bit 0 are both 1.
- R9: The control word reads back the full 32-bit value last written to it.
- R10: Writes to the snapshot word, to offsets 0x10 and above, or to addresses with nonzero low two bits change nothing. Reads of such addresses, and the read data during any write or idle cycle, are zero.
- R11: The counter never runs with a count of zero. A start with a zero count is ignored. A period write of zero while running stops the counter without setting the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero unless a mapped read |
| irq | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
The assertions assume that every access is a whole 32-bit word and that at most one access happens per clock. They also assume that address, data and the write strobe are stable around the sampling edge. The stimulus drives all bus inputs on the falling edge and issues one access per cycle through single-cycle tasks. Misaligned and unmapped addresses are sent on purpose, but always as full-word accesses. No access ever needs more than one cycle.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    localparam int DATA_W = 32;

    // status bit positions
    localparam int ST_TIMEOUT = 0;
    localparam int ST_RUN     = 1;
    // control bit positions
    localparam int CT_IEN   = 0;
    localparam int CT_CONT  = 1;
    localparam int CT_START = 2;
    localparam int CT_STOP  = 3;

    // word indices within the register window
    localparam int IDX_STATUS = 0;
    localparam int IDX_CTRL   = 1;
    localparam int IDX_PERIOD = 2;
    localparam int IDX_SNAP   = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CTRL,
        SEL_PERIOD,
        SEL_SNAP
    } reg_sel_e;

    typedef struct packed {
        logic              flag;
        logic              run;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] count;
    } tmr_state_t;
endpackage

// File: rtl/tdt_decode.sv
module tdt_decode
    import tdt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          wsel,
    output reg_sel_e          rsel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    reg_sel_e         hit;

    always_comb begin
        idx = bus_addr[ADDR_W-1:2];
        hit = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if (idx == IDX_W'(IDX_STATUS))      hit = SEL_STATUS;
            else if (idx == IDX_W'(IDX_CTRL))   hit = SEL_CTRL;
            else if (idx == IDX_W'(IDX_PERIOD)) hit = SEL_PERIOD;
            else if (idx == IDX_W'(IDX_SNAP))   hit = SEL_SNAP;
        end
        wsel = (bus_sel && bus_we)  ? hit : SEL_NONE;
        rsel = (bus_sel && !bus_we) ? hit : SEL_NONE;
    end
endmodule

// File: rtl/tdt_core.sv
module tdt_core
    import tdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          wsel,
    input  logic [DATA_W-1:0] wdata,
    output tmr_state_t        state_q
);
    tmr_state_t state_d;
    logic       expire;

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;

        // counting step, suppressed by a period write in the same cycle
        if (state_q.run && (wsel != SEL_PERIOD)) begin
            if (state_q.count == DATA_W'(1)) begin
                expire       = 1'b1;
                state_d.flag = 1'b1;
                if (state_q.ctrl[CT_CONT] && (state_q.period != '0)) begin
                    state_d.count = state_q.period;
                end else begin
                    state_d.count = '0;
                    state_d.run   = 1'b0;
                end
            end else begin
                state_d.count = state_q.count - DATA_W'(1);
            end
        end

        // register writes
        case (wsel)
            SEL_STATUS: state_d.flag = expire;
            SEL_CTRL: begin
                state_d.ctrl = wdata;
                if (wdata[CT_STOP]) begin
                    state_d.run = 1'b0;
                end else if (wdata[CT_START] && (state_d.count != '0)) begin
                    state_d.run = 1'b1;
                end
            end
            SEL_PERIOD: begin
                state_d.period = wdata;
                state_d.count  = wdata;
                if (wdata == '0) state_d.run = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/tdt_rdmux.sv
module tdt_rdmux
    import tdt_pkg::*;
(
    input  reg_sel_e          rsel,
    input  tmr_state_t        state,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word             = '0;
        status_word[ST_TIMEOUT] = state.flag;
        status_word[ST_RUN]     = state.run;
        case (rsel)
            SEL_STATUS: rdata = status_word;
            SEL_CTRL:   rdata = state.ctrl;
            SEL_PERIOD: rdata = state.period;
            SEL_SNAP:   rdata = state.count;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
    import tdt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    reg_sel_e          wsel;
    reg_sel_e          rsel;
    tmr_state_t        st_q;
    logic              flag_q;
    logic              run_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] count_q;

    tdt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wsel     (wsel),
        .rsel     (rsel)
    );

    tdt_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wsel    (wsel),
        .wdata   (bus_wdata),
        .state_q (st_q)
    );

    tdt_rdmux u_rdmux (
        .rsel  (rsel),
        .state (st_q),
        .rdata (bus_rdata)
    );

    always_comb begin
        flag_q  = st_q.flag;
        run_q   = st_q.run;
        ctrl_q  = st_q.ctrl;
        count_q = st_q.count;
        irq     = flag_q && ctrl_q[CT_IEN];
    end
endmodule

// File: rtl/cntdn_timer_chk.sv
module cntdn_timer_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              flag,
    input logic              run,
    input logic [31:0]       ctrl,
    input logic [31:0]       count
);
    logic wr_status, wr_ctrl, wr_period;

    always_comb begin
        wr_status = bus_sel && bus_we && (bus_addr == ADDR_W'(0));
        wr_ctrl   = bus_sel && bus_we && (bus_addr == ADDR_W'(4));
        wr_period = bus_sel && bus_we && (bus_addr == ADDR_W'(8));
    end

    // R2
    period_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_period |=> count == $past(bus_wdata));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count > 32'd1 && !wr_period) |=> count == $past(count) - 32'd1);

    // R4
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[3]) |=> !run);

    // R5
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == 32'd1 && !wr_period) |=> flag);

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !(run && count == 32'd1)) |=> !flag);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !irq);

    // R11
    no_zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> count != 32'd0);
endmodule

bind cntdn_timer cntdn_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .flag      (flag_q),
    .run       (run_q),
    .ctrl      (ctrl_q),
    .count     (count_q)
);

// File: tb/cntdn_timer_tb.sv
module cntdn_timer_tb;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    bit          m_flag, m_run;
    logic [31:0] m_ctrl, m_period, m_count;
    // model scratch
    bit          n_flag, n_run, hit, wr_ok, pw;
    logic [31:0] n_count;
    int          widx;

    always #10 clk = ~clk;  // 50 MHz

    cntdn_timer #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_rdata();
        if (!bus_sel || bus_we || bus_addr[1:0] != 2'b00) return 32'h0;
        case (int'(bus_addr) / 4)
            0: return {30'h0, m_run, m_flag};
            1: return m_ctrl;
            2: return m_period;
            3: return m_count;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_run = 0; m_ctrl = 0; m_period = 0; m_count = 0;
        end else begin
            widx    = int'(bus_addr) / 4;
            wr_ok   = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
            pw      = wr_ok && widx == 2;
            n_flag  = m_flag; n_run = m_run; n_count = m_count; hit = 0;
            if (m_run && !pw) begin
                if (m_count == 1) begin
                    hit = 1; n_flag = 1;
                    if (m_ctrl[1] && m_period != 0) n_count = m_period;
                    else begin n_count = 0; n_run = 0; end
                end else n_count = m_count - 1;
            end
            if (wr_ok) begin
                if (widx == 0) n_flag = hit;
                else if (widx == 1) begin
                    m_ctrl = bus_wdata;
                    if (bus_wdata[3]) n_run = 0;
                    else if (bus_wdata[2] && n_count != 0) n_run = 1;
                end else if (widx == 2) begin
                    m_period = bus_wdata; n_count = bus_wdata;
                    if (bus_wdata == 0) n_run = 0;
                end
            end
            m_flag = n_flag; m_run = n_run; m_count = n_count;
        end
        #5;
        if (!done) begin
            check("irq", {31'h0, irq}, {31'h0, m_flag && m_ctrl[0]});
            check("rdata", bus_rdata, exp_rdata());
        end
    end

    task automatic acc(bit we, int addr, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = we; bus_addr = AW'(addr); bus_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) acc(0, 12, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset contents
        cur_req = "R1";
        acc(0, 0, 0); acc(0, 4, 0); acc(0, 8, 0); acc(0, 12, 0);
        @(posedge clk); #6 check("irq_after_reset", {31'h0, irq}, 32'h0);
        // R2: period write loads counter
        cur_req = "R2";
        acc(1, 8, 5); acc(0, 8, 0); acc(0, 12, 0);
        // R3/R5: one-shot run of 5 with interrupt enabled
        cur_req = "R3";
        acc(1, 4, 32'h5); idle(3);
        cur_req = "R5";
        idle(5); acc(0, 0, 0);
        // R8: flag and enable both set
        cur_req = "R8";
        @(posedge clk); #6 check("irq_high", {31'h0, irq}, 32'h1);
        // R7: any status write clears flag
        cur_req = "R7";
        acc(1, 0, 32'hFFFF_FFFF); acc(0, 0, 0);
        // R11: start with zero count ignored
        cur_req = "R11";
        acc(1, 4, 32'h4); acc(0, 0, 0); idle(2);
        // R6: continuous, interrupt disabled
        cur_req = "R6";
        acc(1, 8, 3); acc(1, 4, 32'h6); idle(12); acc(0, 0, 0);
        cur_req = "R8";
        idle(1);
        // R7: status write while running keeps run bit
        cur_req = "R7";
        acc(1, 0, 0); acc(0, 0, 0); acc(0, 0, 0);
        // R4: stop, then start+stop together
        cur_req = "R4";
        acc(1, 4, 32'hA); idle(3); acc(0, 0, 0);
        acc(1, 4, 32'hE); acc(0, 0, 0); idle(2);
        acc(1, 4, 32'h4); idle(2);
        // R9: full control word readback (bit 4 set, no start/stop)
        cur_req = "R9";
        acc(1, 4, 32'hABCD_0012); acc(0, 4, 0); idle(2);
        // R10: ignored writes and zero reads
        cur_req = "R10";
        acc(1, 12, 32'h1234); acc(1, 16, 32'hFFFF_FFFF); acc(1, 9, 32'h0);
        acc(1, 60, 32'h7); acc(1, 1, 32'h0);
        acc(0, 16, 0); acc(0, 60, 0); acc(0, 9, 0); acc(0, 8, 0); acc(0, 4, 0);
        // R11: period write of zero while running stops without flag
        cur_req = "R11";
        acc(1, 8, 20); acc(1, 4, 32'h5); idle(4);
        acc(1, 8, 0); acc(0, 0, 0); idle(3); acc(0, 0, 0);
        // R5: one-shot with period 1 expires on the first running edge
        cur_req = "R5";
        acc(1, 8, 1); acc(1, 4, 32'h5); acc(0, 0, 0); idle(2);
        @(negedge clk); bus_sel = 0;
        @(posedge clk); #6;
        finish_run();
    end
endmodule